// File: doc/BRIEF.md
# Dual-Buffer Frame Transmit Engine

This block sends Ethernet frames that a host has placed in one of two on-chip frame buffers, ping and pong. The host writes the frame into a buffer one 32-bit word at a time, writes the frame length into that buffer's length register, and then sets the buffer's busy flag. The engine streams the buffer's bytes onto a byte-wide valid/ready interface and clears the busy flag once the last byte has been accepted. It can raise a one-cycle interrupt at that point.

Each buffer also accepts an address-program command. When the host sets busy and program together, the engine sends nothing. Instead it copies the first six buffer bytes into the station address register. The pong buffer is present only when `HAS_PONG` is 1. When it is 0, pong addresses read as zero and writes to them are ignored.

Host addresses are word offsets, so the ports carry the byte offset divided by four. Host reads are registered: read data appears one cycle after the address.

Top module: `frame_tx_pair`

## Requirements
- R1: After reset, every status register, length register, the global enable, `txValid`, `irq` and `stationAddr` are zero. Each buffer has a status register with busy in bit 0, program in bit 1 and interrupt enable in bit 3 (byte offset 0x7FC for ping, 0xFFC for pong). The global interrupt enable is bit 31 at 0x7F8. A value read at a register address appears on `rdData` in the cycle after the address is presented.
- R2: Each buffer has a length register (0x7F4 for ping, 0xFF4 for pong) that keeps only bits 15:0 of a write. The upper 16 bits read back as zero.
- R3: An armed buffer sends exactly length bytes. The bytes start at buffer word 0, and within each word they go out least-significant byte first, so a partial last word sends only the bytes it still owes. `txLast` is high on the final byte only.
- R4: While `txValid` is high and `txReady` is low, `txValid` stays high and `txData` holds its value.
- R5: The busy flag reads back 1 while a frame is in flight and 0 after its last byte has been accepted.
- R6: When both buffers are armed, they are sent in the order they were armed. All bytes of the first buffer go out before any byte of the second.
- R7: Writing 0x3 to a status register sends no byte. It loads `stationAddr` from the first six buffer bytes, with byte 0 in bits 47:40 and byte 5 in bits 7:0. Afterwards the status reads back 0.
- R8: A length of 0 completes at once with no byte sent. A length above the buffer capacity (4 × `BUF_WORDS` bytes) sends exactly the capacity.
- R9: `irq` is high for exactly one cycle when a buffer finishes, and only if that buffer's interrupt enable and the global enable are both set.
- R10: Writing 0 to the status register of an in-flight buffer stops it. `txValid` falls, busy reads 0, no interrupt is raised and no further byte of that frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Host write strobe |
| wrWordAddr | input | 10 | Host write word offset (byte offset / 4) |
| wrData | input | 32 | Host write data |
| rdWordAddr | input | 10 | Host read word offset |
| rdData | output | 32 | Registered host read data |
| txData | output | 8 | Transmit byte |
| txValid | output | 1 | Transmit byte valid |
| txReady | input | 1 | Sink accepts the byte |
| txLast | output | 1 | Final byte of a frame |
| irq | output | 1 | One-cycle transmit-done pulse |
| stationAddr | output | 48 | Programmed station address |

## Verification
The engine is tried with several frame shapes: a short frame whose length ends inside a word, a zero-length frame, and a frame longer than the buffer. Together these separate the byte-lane order, the exact-count logic and the capacity clamp. A sink that stalls on a fixed rhythm shows whether data is held under backpressure. Arming pong and then ping while the sink is stalled shows whether arm order is kept. The address-program command, a cancel during a stall, and each one-sided interrupt enable check that these paths send no bytes and raise no stray pulses.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;
  localparam int LEN_W = 16;
  localparam int IDX_W = 9;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_LOAD, ST_FINISH} txState_e;

  typedef struct packed {
    logic             bufSel;
    logic [IDX_W-1:0] wordIdx;
    logic [1:0]       byteSel;
    logic             macHi;
    logic             macLo;
  } dpCtl_t;
endpackage

// File: rtl/frame_tx_dp.sv
module frame_tx_dp
  import frame_tx_pkg::*;
#(
  parameter int BUF_WORDS = 64,
  parameter bit HAS_PONG  = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [9:0]  wrWordAddr,
  input  logic [31:0] wrData,
  input  dpCtl_t      ctl,
  output logic [7:0]  txData,
  output logic [47:0] stationAddr
);
  localparam int NUM_BUF = HAS_PONG ? 2 : 1;
  localparam logic [IDX_W-1:0] WORD_LIM = IDX_W'(BUF_WORDS);

  logic [31:0] bufWord [NUM_BUF];
  logic [31:0] selWord;

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    logic [31:0] ram [BUF_WORDS];
    logic        hit;
    assign hit = wrEn && (wrWordAddr[9] == (b == 1)) && (wrWordAddr[8:0] < WORD_LIM);
    always_ff @(posedge clk) begin
      if (hit) ram[wrWordAddr[8:0]] <= wrData;
    end
    assign bufWord[b] = ram[ctl.wordIdx];
  end

  assign selWord = (NUM_BUF > 1 && ctl.bufSel) ? bufWord[NUM_BUF-1] : bufWord[0];
  assign txData  = selWord[8*ctl.byteSel +: 8];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stationAddr <= '0;
    end else begin
      if (ctl.macHi) stationAddr[47:16] <= {selWord[7:0], selWord[15:8], selWord[23:16], selWord[31:24]};
      if (ctl.macLo) stationAddr[15:0]  <= {selWord[7:0], selWord[15:8]};
    end
  end
endmodule

// File: rtl/frame_tx_ctl.sv
module frame_tx_ctl
  import frame_tx_pkg::*;
#(
  parameter int BUF_WORDS = 64,
  parameter bit HAS_PONG  = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [9:0]  wrWordAddr,
  input  logic [16:0] regWrData,
  input  logic [9:0]  rdWordAddr,
  output logic [31:0] rdData,
  input  logic        txReady,
  output logic        txValid,
  output logic        txLast,
  output logic        irq,
  output dpCtl_t      ctl
);
  localparam logic [LEN_W-1:0] MAX_BYTES = LEN_W'(BUF_WORDS * 4);
  localparam logic [1:0] BUF_OK = HAS_PONG ? 2'b11 : 2'b01;
  localparam logic [8:0] IDX_LEN  = 9'h1FD;
  localparam logic [8:0] IDX_GIE  = 9'h1FE;
  localparam logic [8:0] IDX_STAT = 9'h1FF;

  txState_e         state;
  logic [1:0]       busy, prog, ie;
  logic [LEN_W-1:0] lenReg [2];
  logic [LEN_W-1:0] effLen [2];
  logic             gie, olderPong, act;
  logic [LEN_W-1:0] cnt;
  logic [1:0]       statWr, lenWr;
  logic             gieWr, pickSel, cancelNow, stopAct;
  logic [LEN_W-1:0] actLen;

  always_comb begin
    for (int b = 0; b < 2; b++) begin
      effLen[b] = (lenReg[b] > MAX_BYTES) ? MAX_BYTES : lenReg[b];
      statWr[b] = wrEn && BUF_OK[b] && (wrWordAddr[9] == b[0]) && (wrWordAddr[8:0] == IDX_STAT);
      lenWr[b]  = wrEn && BUF_OK[b] && (wrWordAddr[9] == b[0]) && (wrWordAddr[8:0] == IDX_LEN);
    end
    gieWr     = wrEn && !wrWordAddr[9] && (wrWordAddr[8:0] == IDX_GIE);
    pickSel   = (busy[0] && busy[1]) ? olderPong : busy[1];
    actLen    = effLen[act];
    cancelNow = statWr[act] && !regWrData[0];
    stopAct   = cancelNow || !busy[act];
  end

  assign txValid = (state == ST_SEND) && busy[act];
  assign txLast  = txValid && (cnt == actLen - LEN_W'(1));

  always_comb begin
    ctl         = '0;
    ctl.bufSel  = act;
    ctl.wordIdx = cnt[IDX_W+1:2];
    ctl.byteSel = cnt[1:0];
    ctl.macHi   = (state == ST_LOAD) && !stopAct && (cnt == '0);
    ctl.macLo   = (state == ST_LOAD) && !stopAct && (cnt != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      busy      <= '0;
      prog      <= '0;
      ie        <= '0;
      lenReg[0] <= '0;
      lenReg[1] <= '0;
      gie       <= 1'b0;
      olderPong <= 1'b0;
      act       <= 1'b0;
      cnt       <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= 1'b0;
      unique case (state)
        ST_IDLE: if (|busy) begin
          act <= pickSel;
          cnt <= '0;
          if (prog[pickSel])             state <= ST_LOAD;
          else if (effLen[pickSel] == 0) state <= ST_FINISH;
          else                           state <= ST_SEND;
        end
        ST_SEND: begin
          if (stopAct) state <= ST_IDLE;
          else if (txReady) begin
            if (cnt == actLen - LEN_W'(1)) state <= ST_FINISH;
            else cnt <= cnt + LEN_W'(1);
          end
        end
        ST_LOAD: begin
          if (stopAct) state <= ST_IDLE;
          else if (cnt == '0) cnt <= LEN_W'(4);
          else state <= ST_FINISH;
        end
        ST_FINISH: begin
          busy[act] <= 1'b0;
          prog[act] <= 1'b0;
          irq       <= ie[act] && gie;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
      for (int b = 0; b < 2; b++) begin
        if (statWr[b]) begin
          busy[b] <= regWrData[0];
          prog[b] <= regWrData[1];
          ie[b]   <= regWrData[3];
          if (regWrData[0] && !busy[b]) olderPong <= busy[1-b] ? (b == 0) : (b == 1);
        end
        if (lenWr[b]) lenReg[b] <= regWrData[15:0];
      end
      if (gieWr) gie <= regWrData[16];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else begin
      rdData <= '0;
      if (BUF_OK[rdWordAddr[9]]) begin
        if (rdWordAddr[8:0] == IDX_STAT)
          rdData <= {28'b0, ie[rdWordAddr[9]], 1'b0, prog[rdWordAddr[9]], busy[rdWordAddr[9]]};
        else if (rdWordAddr[8:0] == IDX_LEN)
          rdData <= {16'b0, lenReg[rdWordAddr[9]]};
        else if (rdWordAddr[8:0] == IDX_GIE && !rdWordAddr[9])
          rdData <= {gie, 31'b0};
      end
    end
  end
endmodule

// File: rtl/frame_tx_pair.sv
module frame_tx_pair
  import frame_tx_pkg::*;
#(
  parameter int BUF_WORDS = 64,
  parameter bit HAS_PONG  = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [9:0]  wrWordAddr,
  input  logic [31:0] wrData,
  input  logic [9:0]  rdWordAddr,
  output logic [31:0] rdData,
  output logic [7:0]  txData,
  output logic        txValid,
  input  logic        txReady,
  output logic        txLast,
  output logic        irq,
  output logic [47:0] stationAddr
);
  dpCtl_t ctlBus;

  frame_tx_ctl #(.BUF_WORDS(BUF_WORDS), .HAS_PONG(HAS_PONG)) uCtl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrWordAddr(wrWordAddr),
    .regWrData({wrData[31], wrData[15:0]}), .rdWordAddr(rdWordAddr),
    .rdData(rdData), .txReady(txReady), .txValid(txValid), .txLast(txLast),
    .irq(irq), .ctl(ctlBus)
  );

  frame_tx_dp #(.BUF_WORDS(BUF_WORDS), .HAS_PONG(HAS_PONG)) uDp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrWordAddr(wrWordAddr),
    .wrData(wrData), .ctl(ctlBus), .txData(txData), .stationAddr(stationAddr)
  );
endmodule

// File: rtl/frame_tx_pair_chk.sv
module frame_tx_pair_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic        txValid,
  input logic        txReady,
  input logic        txLast,
  input logic [7:0]  txData,
  input logic        irq,
  input logic [47:0] stationAddr,
  input logic        macHi,
  input logic        macLo
);
  assert_last_with_valid_R3: assert property (@(posedge clk) disable iff (!rstN)
    txLast |-> txValid);

  assert_hold_on_stall_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady && !wrEn) |=> (txValid && $stable(txData)));

  assert_mac_from_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(stationAddr) |-> ($past(macHi) || $past(macLo)));

  assert_load_sends_nothing_R7: assert property (@(posedge clk) disable iff (!rstN)
    (macHi || macLo) |-> !txValid);

  assert_irq_one_cycle_R9: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
endmodule

bind frame_tx_pair frame_tx_pair_chk uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .txValid(txValid), .txReady(txReady),
  .txLast(txLast), .txData(txData), .irq(irq), .stationAddr(stationAddr),
  .macHi(ctlBus.macHi), .macLo(ctlBus.macLo)
);

// File: tb/sim_frame_tx_pair.sv
module sim_frame_tx_pair;
  localparam int BUF_WORDS = 64;
  localparam logic [9:0] PING_BUF = 10'h000, PING_LEN = 10'h1FD, GIE = 10'h1FE, PING_ST = 10'h1FF;
  localparam logic [9:0] PONG_BUF = 10'h200, PONG_LEN = 10'h3FD, PONG_ST = 10'h3FF;

  logic        clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, txReady = 1'b0;
  logic [9:0]  wrWordAddr = '0, rdWordAddr = '0;
  logic [31:0] wrData = '0, rdData;
  logic [7:0]  txData;
  logic        txValid, txLast, irq;
  logic [47:0] stationAddr;

  int nChecks = 0, nFail = 0;
  int readyMode = 0, cyc = 0;
  logic [7:0] got[$];
  int lastSeen = 0, irqCnt = 0, validCyc = 0, holdBad = 0;
  logic prevStall = 1'b0;
  logic [7:0] prevData = '0;

  frame_tx_pair #(.BUF_WORDS(BUF_WORDS), .HAS_PONG(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrWordAddr(wrWordAddr), .wrData(wrData),
    .rdWordAddr(rdWordAddr), .rdData(rdData), .txData(txData), .txValid(txValid),
    .txReady(txReady), .txLast(txLast), .irq(irq), .stationAddr(stationAddr)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    #1;
    cyc++;
    case (readyMode)
      0: txReady = 1'b1;
      1: txReady = (cyc % 3) != 0;
      default: txReady = 1'b0;
    endcase
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall && !(txValid && txData == prevData)) holdBad++;
      prevStall = txValid && !txReady && !wrEn;
      prevData  = txData;
      if (txValid) validCyc++;
      if (txValid && txReady) begin
        got.push_back(txData);
        if (txLast) lastSeen++;
      end
      if (irq) irqCnt++;
    end
  end

  function automatic logic [7:0] expByte(input int seed, input int k);
    return 8'(seed + k * 3);
  endfunction

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic hostWr(input logic [9:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wrEn = 1'b1; wrWordAddr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic hostRd(input logic [9:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    rdWordAddr = a;
    @(posedge clk); #2;
    d = rdData;
  endtask

  task automatic fillBuf(input logic [9:0] base, input int nBytes, input int seed);
    for (int w = 0; w < (nBytes + 3) / 4; w++)
      hostWr(base + 10'(w), {expByte(seed, 4*w+3), expByte(seed, 4*w+2), expByte(seed, 4*w+1), expByte(seed, 4*w)});
  endtask

  task automatic waitIdle(input logic [9:0] st, input string req);
    logic [31:0] v;
    int tries = 0;
    v = 32'h1;
    while (v[0] && tries < 3000) begin hostRd(st, v); tries++; end
    check(v[0] == 1'b0, req, "busy never cleared", v, 0);
    repeat (3) @(posedge clk);
  endtask

  task automatic checkFrame(input int startIdx, input int n, input int seed, input string req);
    bit ok = 1'b1;
    int bad = 0;
    for (int k = 0; k < n; k++)
      if (startIdx + k >= got.size() || got[startIdx+k] !== expByte(seed, k)) begin ok = 1'b0; bad = k; end
    check(ok, req, $sformatf("byte %0d", bad),
          (startIdx + bad < got.size()) ? got[startIdx+bad] : -1, expByte(seed, bad));
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check(txValid == 1'b0 && irq == 1'b0, "R1", "txValid/irq after reset", {txValid, irq}, 0);
    check(stationAddr == '0, "R1", "stationAddr after reset", stationAddr, 0);
    hostRd(PING_ST, v);  check(v == 0, "R1", "ping status reset", v, 0);
    hostRd(PONG_ST, v);  check(v == 0, "R1", "pong status reset", v, 0);
    hostRd(PING_LEN, v); check(v == 0, "R1", "ping length reset", v, 0);
    hostRd(GIE, v);      check(v == 0, "R1", "global enable reset", v, 0);
  endtask

  task automatic t_lenReg;
    logic [31:0] v;
    hostWr(PING_LEN, 32'hABCD_1234); hostRd(PING_LEN, v);
    check(v == 32'h1234, "R2", "ping length keeps 16 bits", v, 32'h1234);
    hostWr(PONG_LEN, 32'h5A5A_00FE); hostRd(PONG_LEN, v);
    check(v == 32'h00FE, "R2", "pong length keeps 16 bits", v, 32'h00FE);
    hostWr(GIE, 32'h8000_0000); hostRd(GIE, v);
    check(v == 32'h8000_0000, "R1", "global enable bit 31", v, 32'h8000_0000);
  endtask

  task automatic t_basic;
    logic [31:0] v;
    int i0, l0;
    got.delete(); i0 = irqCnt; l0 = lastSeen; readyMode = 2;
    fillBuf(PING_BUF, 7, 8'h10);
    hostWr(PING_LEN, 7); hostWr(PING_ST, 32'h9);
    hostRd(PING_ST, v);
    check(v == 32'h9, "R5", "busy while in flight", v, 32'h9);
    readyMode = 0;
    waitIdle(PING_ST, "R5");
    check(got.size() == 7, "R3", "byte count of 7-byte frame", got.size(), 7);
    checkFrame(0, 7, 8'h10, "R3");
    check(lastSeen - l0 == 1, "R3", "txLast count", lastSeen - l0, 1);
    check(irqCnt - i0 == 1, "R9", "irq pulses on finish", irqCnt - i0, 1);
  endtask

  task automatic t_stall;
    got.delete(); readyMode = 1; holdBad = 0;
    fillBuf(PONG_BUF, 9, 8'h40);
    hostWr(PONG_LEN, 9); hostWr(PONG_ST, 32'h1);
    waitIdle(PONG_ST, "R4");
    readyMode = 0;
    check(got.size() == 9, "R4", "byte count under stalls", got.size(), 9);
    checkFrame(0, 9, 8'h40, "R4");
    check(holdBad == 0, "R4", "data held while stalled", holdBad, 0);
  endtask

  task automatic t_order;
    got.delete(); readyMode = 2;
    fillBuf(PONG_BUF, 5, 8'h80);
    fillBuf(PING_BUF, 6, 8'hA0);
    hostWr(PONG_LEN, 5); hostWr(PING_LEN, 6);
    hostWr(PONG_ST, 32'h1); hostWr(PING_ST, 32'h1);
    readyMode = 0;
    waitIdle(PONG_ST, "R6");
    waitIdle(PING_ST, "R6");
    check(got.size() == 11, "R6", "total bytes of two frames", got.size(), 11);
    checkFrame(0, 5, 8'h80, "R6");
    checkFrame(5, 6, 8'hA0, "R6");
  endtask

  task automatic t_prog;
    logic [31:0] v;
    int vc0;
    got.delete(); vc0 = validCyc;
    hostWr(PING_BUF, 32'h3322_1102); hostWr(PING_BUF + 10'd1, 32'hDEAD_5544);
    hostWr(PING_LEN, 6); hostWr(PING_ST, 32'h3);
    waitIdle(PING_ST, "R7");
    hostRd(PING_ST, v);
    check(v == 0, "R7", "status after address load", v, 0);
    check(stationAddr == 48'h0211_2233_4455, "R7", "station address", stationAddr, 48'h0211_2233_4455);
    check(validCyc == vc0 && got.size() == 0, "R7", "no byte sent by load", validCyc - vc0, 0);
  endtask

  task automatic t_lenCorners;
    int i0;
    got.delete(); i0 = irqCnt;
    hostWr(PING_LEN, 0); hostWr(PING_ST, 32'h9);
    waitIdle(PING_ST, "R8");
    check(got.size() == 0, "R8", "zero length sends nothing", got.size(), 0);
    check(irqCnt - i0 == 1, "R8", "zero length still completes", irqCnt - i0, 1);
    fillBuf(PONG_BUF, BUF_WORDS * 4, 8'h05);
    hostWr(PONG_LEN, 300); hostWr(PONG_ST, 32'h1);
    waitIdle(PONG_ST, "R8");
    check(got.size() == BUF_WORDS * 4, "R8", "oversize length clamped", got.size(), BUF_WORDS * 4);
    checkFrame(0, BUF_WORDS * 4, 8'h05, "R8");
  endtask

  task automatic t_irqGate;
    int i0;
    i0 = irqCnt;
    hostWr(GIE, 32'h0);
    hostWr(PING_LEN, 2); hostWr(PING_ST, 32'h9);
    waitIdle(PING_ST, "R9");
    check(irqCnt == i0, "R9", "no irq without global enable", irqCnt - i0, 0);
    hostWr(GIE, 32'h8000_0000);
    hostWr(PONG_LEN, 2); hostWr(PONG_ST, 32'h1);
    waitIdle(PONG_ST, "R9");
    check(irqCnt == i0, "R9", "no irq without buffer enable", irqCnt - i0, 0);
    got.delete();
  endtask

  task automatic t_cancel;
    logic [31:0] v;
    int i0;
    got.delete(); i0 = irqCnt; readyMode = 2;
    hostWr(PING_LEN, 4); hostWr(PING_ST, 32'h9);
    repeat (3) @(posedge clk);
    #2;
    check(txValid == 1'b1, "R10", "frame presented before cancel", txValid, 1);
    hostWr(PING_ST, 32'h0);
    repeat (2) @(posedge clk);
    #2;
    check(txValid == 1'b0, "R10", "txValid after cancel", txValid, 0);
    readyMode = 0;
    repeat (10) @(posedge clk);
    hostRd(PING_ST, v);
    check(v == 0, "R10", "status after cancel", v, 0);
    check(got.size() == 0 && irqCnt == i0, "R10", "no bytes or irq after cancel", got.size() + irqCnt - i0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R3 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_lenReg();
    t_basic();
    t_stall();
    t_order();
    t_prog();
    t_lenCorners();
    t_irqGate();
    t_cancel();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule